// File: doc/BRIEF.md
# Paged Interrupt Priority Register File

This block stores a 3-bit priority level for each of 128 interrupt vectors. Software does not see the 128 levels directly. It sees a small register window: one page register and eight slot registers. The page register picks a group of eight neighbouring vectors, and each slot register reads or writes the level of one vector in that group. All 128 levels leave the block on one flat bus, which an interrupt arbiter next to it uses.

To find where a vector's level lives, divide the vector's byte offset in the vector table by four. This gives a 7-bit vector index. The upper four bits of the index are the page, and the lower three bits pick the slot. The page register holds the index with its low three bits cleared. For example, writing 0x40 to the page register exposes the vectors at offsets 0x100, 0x104, and so on up to 0x11C. A level of 0 marks a vector as effectively disabled. A level can be written at any time, whether or not its source is enabled. Interrupt enables, vector fetch and arbitration are handled outside this block.

Top module: `irq_prio_bank`

## Requirements
- R1: After reset every one of the 128 levels is 1 and the page register reads 0x00.
- R2: Window offset 0 is the page register. A write stores write-data bits [6:3] as the page, and bits [2:0] and [7] are ignored. A read returns {1'b0, page, 3'b000}.
- R3: Window offsets 8 to 15 are slot registers 0 to 7. A write to slot s sets the level of vector index page*8+s, which is the vector at byte offset 4*(page*8+s). The new level appears on the output one clock after the write.
- R4: Write-data bits [7:3] of a slot write are ignored. A slot read returns the stored level in bits [2:0], with bits [7:3] zero.
- R5: Reads are combinational. rd_data follows addr and the stored state in the same cycle, with no clock needed.
- R6: A slot write changes only the addressed vector's level. A cycle with no write leaves every level unchanged.
- R7: Window offsets 1 to 7 are unmapped. Writes to them change no level and do not change the page, and reads from them return 0.
- R8: Level 0, the disabled encoding, is stored and exported like any other level. Vector v's level appears on prio_levels bits [3v+2:3v].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 4 | Register window offset |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Combinational read data |
| prio_levels | output | 384 | All vector levels, 3 bits per vector |

## Verification
The assertions check the following on every cycle:
- A slot write lands on the vector selected by the current page, with the written value.
- A cycle with no write leaves all 384 output bits unchanged.
- Page reads never show bits [2:0] or [7] set.
- Slot reads keep their upper bits zero.
- Unmapped offsets read zero.

Some behaviours only the bench's scenarios can show:
- The reset default on all vectors.
- That writes to unmapped offsets and ignored data bits leave the page and the levels untouched.
- That every page and slot pair maps to a distinct vector. The bench shows this by sweeping all 128 index combinations against an arithmetic model.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
    typedef enum logic [1:0] {
        SEL_PAGE = 2'd0,
        SEL_SLOT = 2'd1,
        SEL_NONE = 2'd2
    } win_sel_e;
endpackage

// File: rtl/irq_prio_decode.sv
module irq_prio_decode
    import irq_prio_pkg::*;
#(
    parameter int SLOT_W = 3,
    localparam int ADDR_W = SLOT_W + 1
) (
    input  logic [ADDR_W-1:0] addr,
    output win_sel_e          sel,
    output logic [SLOT_W-1:0] slot
);
    always_comb begin
        slot = addr[SLOT_W-1:0];
        if (addr[ADDR_W-1]) begin
            sel = SEL_SLOT;
        end else if (addr[SLOT_W-1:0] == '0) begin
            sel = SEL_PAGE;
        end else begin
            sel = SEL_NONE;
        end
    end
endmodule

// File: rtl/irq_prio_page.sv
module irq_prio_page #(
    parameter int PAGE_W = 4,
    parameter int SLOT_W = 3,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_page,
    input  logic [DATA_W-1:0] wr_data,
    output logic [PAGE_W-1:0] page
);
    typedef struct packed {
        logic [PAGE_W-1:0] page;
    } page_st_t;

    page_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_page) begin
            st_d.page = wr_data[SLOT_W +: PAGE_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign page = st_q.page;
endmodule

// File: rtl/irq_prio_store.sv
module irq_prio_store #(
    parameter int NUM_VEC = 128,
    parameter int PRIO_W  = 3,
    parameter int RST_LVL = 1,
    localparam int IDX_W  = $clog2(NUM_VEC)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_slot,
    input  logic [IDX_W-1:0]          idx,
    input  logic [PRIO_W-1:0]         wr_lvl,
    output logic [PRIO_W-1:0]         rd_lvl,
    output logic [NUM_VEC*PRIO_W-1:0] levels
);
    localparam logic [PRIO_W-1:0] RST_VAL = PRIO_W'(RST_LVL);

    typedef struct packed {
        logic [NUM_VEC-1:0][PRIO_W-1:0] lvl;
    } store_st_t;

    store_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_slot) begin
            st_d.lvl[idx] = wr_lvl;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.lvl <= {NUM_VEC{RST_VAL}};
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_lvl = st_q.lvl[idx];

    for (genvar v = 0; v < NUM_VEC; v++) begin : g_flat
        assign levels[v*PRIO_W +: PRIO_W] = st_q.lvl[v];
    end
endmodule

// File: rtl/irq_prio_bank.sv
module irq_prio_bank
    import irq_prio_pkg::*;
#(
    parameter int NUM_VEC  = 128,
    parameter int SLOTS    = 8,
    parameter int PRIO_W   = 3,
    parameter int DATA_W   = 8,
    parameter int RST_LVL  = 1,
    localparam int SLOT_W  = $clog2(SLOTS),
    localparam int PAGE_W  = $clog2(NUM_VEC / SLOTS),
    localparam int IDX_W   = SLOT_W + PAGE_W,
    localparam int ADDR_W  = SLOT_W + 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [ADDR_W-1:0]         addr,
    input  logic                      wr_en,
    input  logic [DATA_W-1:0]         wr_data,
    output logic [DATA_W-1:0]         rd_data,
    output logic [NUM_VEC*PRIO_W-1:0] prio_levels
);
    win_sel_e          sel;
    logic [SLOT_W-1:0] slot;
    logic [PAGE_W-1:0] page_q;
    logic [PRIO_W-1:0] rd_lvl;
    logic              wr_page;
    logic              wr_slot;

    irq_prio_decode #(.SLOT_W(SLOT_W)) u_dec (
        .addr (addr),
        .sel  (sel),
        .slot (slot)
    );

    assign wr_page = wr_en && (sel == SEL_PAGE);
    assign wr_slot = wr_en && (sel == SEL_SLOT);

    irq_prio_page #(
        .PAGE_W (PAGE_W),
        .SLOT_W (SLOT_W),
        .DATA_W (DATA_W)
    ) u_page (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_page (wr_page),
        .wr_data (wr_data),
        .page    (page_q)
    );

    irq_prio_store #(
        .NUM_VEC (NUM_VEC),
        .PRIO_W  (PRIO_W),
        .RST_LVL (RST_LVL)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_slot (wr_slot),
        .idx     ({page_q, slot}),
        .wr_lvl  (wr_data[PRIO_W-1:0]),
        .rd_lvl  (rd_lvl),
        .levels  (prio_levels)
    );

    always_comb begin
        rd_data = '0;
        unique case (sel)
            SEL_PAGE: rd_data[SLOT_W +: PAGE_W] = page_q;
            SEL_SLOT: rd_data[PRIO_W-1:0] = rd_lvl;
            default:  rd_data = '0;
        endcase
    end
endmodule

// File: rtl/irq_prio_bank_chk.sv
module irq_prio_bank_chk #(
    parameter int NUM_VEC = 128,
    parameter int PRIO_W  = 3,
    parameter int DATA_W  = 8,
    parameter int SLOT_W  = 3,
    parameter int PAGE_W  = 4
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic [SLOT_W:0]           addr,
    input logic                      wr_en,
    input logic [DATA_W-1:0]         wr_data,
    input logic [DATA_W-1:0]         rd_data,
    input logic [PAGE_W-1:0]         page_q,
    input logic [NUM_VEC*PRIO_W-1:0] prio_levels
);
    localparam int IDX_W = SLOT_W + PAGE_W;

    logic              last_wr;
    logic [IDX_W-1:0]  last_idx;
    logic [PRIO_W-1:0] last_val;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last_wr  <= 1'b0;
            last_idx <= '0;
            last_val <= '0;
        end else begin
            last_wr  <= wr_en && addr[SLOT_W];
            last_idx <= {page_q, addr[SLOT_W-1:0]};
            last_val <= wr_data[PRIO_W-1:0];
        end
    end

    AST_SLOT_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        last_wr |-> prio_levels[last_idx*PRIO_W +: PRIO_W] == last_val); // R3

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(prio_levels)); // R6

    AST_PAGE_READ_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == '0) |-> (rd_data[SLOT_W-1:0] == '0 && rd_data[DATA_W-1] == 1'b0)); // R2

    AST_SLOT_READ_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        addr[SLOT_W] |-> rd_data[DATA_W-1:PRIO_W] == '0); // R4

    AST_UNMAPPED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (!addr[SLOT_W] && addr != '0) |-> rd_data == '0); // R7
endmodule

bind irq_prio_bank irq_prio_bank_chk #(
    .NUM_VEC (NUM_VEC),
    .PRIO_W  (PRIO_W),
    .DATA_W  (DATA_W),
    .SLOT_W  (SLOT_W),
    .PAGE_W  (PAGE_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .addr        (addr),
    .wr_en       (wr_en),
    .wr_data     (wr_data),
    .rd_data     (rd_data),
    .page_q      (page_q),
    .prio_levels (prio_levels)
);

// File: tb/tb_irq_prio_bank.sv
module tb_irq_prio_bank;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [3:0]   addr = '0;
    logic         wr_en = 1'b0;
    logic [7:0]   wr_data = '0;
    logic [7:0]   rd_data;
    logic [383:0] prio_levels;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    logic [2:0] mdl [128];
    logic [3:0] mpage;

    always #2 clk = ~clk;

    irq_prio_bank dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .addr        (addr),
        .wr_en       (wr_en),
        .wr_data     (wr_data),
        .rd_data     (rd_data),
        .prio_levels (prio_levels)
    );

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a;
        wr_en = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        wr_data = '0;
    endtask

    task automatic chk_rd(input logic [3:0] a, input logic [7:0] exp, input string req);
        addr = a;
        #1;
        total++;
        if (rd_data !== exp) begin
            bad++;
            $display("FAIL %s read addr=%0d actual=%02h expected=%02h", req, a, rd_data, exp);
        end
    endtask

    task automatic chk_flat(input string req);
        total++;
        for (int v = 0; v < 128; v++) begin
            if (prio_levels[v*3 +: 3] !== mdl[v]) begin
                bad++;
                $display("FAIL %s vector=%0d actual=%0d expected=%0d",
                         req, v, prio_levels[v*3 +: 3], mdl[v]);
                break;
            end
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int v = 0; v < 128; v++) mdl[v] = 3'd1;
        mpage = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset defaults
        chk_flat("R1");
        chk_rd(4'd0, 8'h00, "R1");
        for (int s = 0; s < 8; s++) chk_rd(4'(8 + s), 8'h01, "R1");

        // R2: page write drops bits 2:0 and 7
        wr(4'd0, 8'hFF);
        mpage = 4'hF;
        chk_rd(4'd0, 8'h78, "R2");
        wr(4'd0, 8'h43);
        mpage = 4'h8;
        chk_rd(4'd0, 8'h40, "R2");

        // R7: unmapped offsets have no effect and read zero
        for (int a = 1; a < 8; a++) begin
            wr(4'(a), 8'hFF);
            chk_rd(4'(a), 8'h00, "R7");
        end
        chk_rd(4'd0, 8'h40, "R7");
        chk_flat("R7");

        // R3/R8: vector at offset 0x100 -> index 0x40 -> page 0x40 slot 0, level 0
        wr(4'd8, 8'hF8);
        mdl[64] = 3'd0;
        chk_flat("R8");
        chk_rd(4'd8, 8'h00, "R8");
        chk_rd(4'd9, 8'h01, "R3");

        // R3/R4/R5/R6: full sweep of all pages and slots
        for (int p = 0; p < 16; p++) begin
            logic [7:0] pd;
            pd = 8'((p << 3) | 5 | ((p & 1) << 7));
            wr(4'd0, pd);
            mpage = 4'(p);
            chk_rd(4'd0, 8'(p << 3), "R2");
            for (int s = 0; s < 8; s++) begin
                int idx;
                logic [2:0] val;
                idx = p * 8 + s;
                val = 3'((idx * 5 + p + 3) % 8);
                wr(4'(8 + s), {5'(idx + 9), val});
                mdl[idx] = val;
                chk_flat("R6");
            end
            for (int s = 0; s < 8; s++) begin
                chk_rd(4'(8 + s), {5'b0, mdl[p * 8 + s]}, "R4");
            end
        end

        // R5: read follows addr with no clock edge
        @(negedge clk);
        for (int s = 7; s >= 0; s--) chk_rd(4'(8 + s), {5'b0, mdl[15 * 8 + s]}, "R5");

        // R6: idle cycles hold every level
        repeat (5) @(negedge clk);
        chk_flat("R6");

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule